// File: doc/BRIEF.md
# Indirect Register Write Engine

This block gives a command microcontroller a compact way to write long runs of registers. Firmware loads one of two address registers and then pushes values through a single data port. The engine routes each value either to the GPU register space or to the pipe register space, depending on the magnitude of the active address, and then steps that address so the next value lands on the following register.

An address up to 0xFFFF names a GPU register and steps by one. A larger address names a pipe register: its index is the top byte, bit 18 freezes the address, and otherwise only the top byte advances. Some pipe registers carry no value ("void"). Loading an address that points at one of these triggers a zero write to it right away. An external per-index map says which indices are void. A pipe address with stray bits set is rejected with an error pulse.

Commands arrive on a valid/ready port. Each output write port is a single valid/ready holding stage. A command is accepted only when both output stages are empty or are being drained in the same cycle. While a downstream write is stalled, `cmd_ready` stays low and the stalled write holds its fields.

Top module: `ridx_engine`

## Requirements
- R1: After reset both address registers read 0, address A is active (`act_b`=0), and `gpu_valid`, `pipe_valid` and `addr_err` are low.
- R2: An accepted command with `cmd_sel`=0 (or 1) stores `cmd_data` into address register A (or B), where it can be read back on `addr_a` (or `addr_b`), and makes that register the active one (`act_b` = `cmd_sel`[0]).
- R3: An accepted data command (`cmd_sel`=2) whose active address is at most 0xFFFF raises `gpu_valid` in the next cycle, with `gpu_addr` = address[15:0] and `gpu_data` = `cmd_data`. The active address then becomes address+1, so 0xFFFF steps to 0x10000.
- R4: An accepted data command whose active address exceeds 0xFFFF and is well formed raises `pipe_valid` in the next cycle, with `pipe_idx` = address[31:24] and `pipe_data` = `cmd_data`. With bit 18 clear, the active address gains 0x01000000, wrapping modulo 2^32.
- R5: With bit 18 of a well-formed pipe address set, data commands leave the active address unchanged.
- R6: A pipe address is malformed when any of bits 23:19 or 17:0 is set. A data command through a malformed address, or an address command that loads one, produces a one-cycle `addr_err` in the next cycle, no write on either port, and no change to the active address.
- R7: An address command that loads a well-formed pipe address whose index has `void_map`[index]=1 issues a pipe write of 0 to that index in the next cycle. A non-void index gives no write, and address steps caused by data writes never cause such writes.
- R8: While `gpu_valid` (or `pipe_valid`) is high and its ready is low, the write stays valid with stable fields and `cmd_ready` is low.
- R9: A command with `cmd_sel`=3 is accepted and has no effect on the addresses, the active selection or either write port.
- R10: `gpu_valid` and `pipe_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_sel | input | 2 | 0 load address A, 1 load address B, 2 data, 3 reserved |
| cmd_data | input | 32 | Address or data value |
| void_map | input | 256 | Bit i high marks pipe index i as void |
| gpu_valid | output | 1 | GPU register write pending |
| gpu_ready | input | 1 | GPU register write taken |
| gpu_addr | output | 16 | GPU register offset |
| gpu_data | output | 32 | GPU register value |
| pipe_valid | output | 1 | Pipe register write pending |
| pipe_ready | input | 1 | Pipe register write taken |
| pipe_idx | output | 8 | Pipe register index |
| pipe_data | output | 32 | Pipe register value |
| addr_err | output | 1 | One-cycle pulse for a malformed pipe address |
| addr_a | output | 32 | Readback of address register A |
| addr_b | output | 32 | Readback of address register B |
| act_b | output | 1 | High when address B is the active source |

## Verification
A wrong active selection or a missed step shows up on the very next data command, because the write comes out on the wrong port or at the wrong offset one cycle after acceptance. The readback ports expose the same fault in the cycle after the data command. The sweep visits every pipe index with bit 18 both set and clear. It also crosses the 0xFFFF boundary and the top-byte wrap, so a mistake in range classification or in increment width shows up within a few commands. A mistake in the stall logic shows as a changed field or as `cmd_ready` rising while a write is still held.

// File: rtl/ridx_pkg.sv
package ridx_pkg;
  parameter int ADDR_W   = 32;
  parameter int GPU_AW   = 16;
  parameter int PIPE_IW  = 8;
  parameter int HOLD_BIT = 18;

  localparam int PIPE_LSB = ADDR_W - PIPE_IW;
  localparam int PIPE_N   = 1 << PIPE_IW;

  typedef enum logic [1:0] {
    SEL_ADDR_A = 2'd0,
    SEL_ADDR_B = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_RSVD   = 2'd3
  } sel_e;
endpackage

// File: rtl/ridx_classify.sv
module ridx_classify
  import ridx_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic [PIPE_N-1:0]  void_map,
  output logic               is_pipe,
  output logic               bad,
  output logic               hold,
  output logic               void_hit,
  output logic [PIPE_IW-1:0] idx
);
  localparam logic [ADDR_W-1:0] LOW_ONES  = {{PIPE_IW{1'b0}}, {PIPE_LSB{1'b1}}};
  localparam logic [ADDR_W-1:0] HOLD_MASK = ADDR_W'(1) << HOLD_BIT;
  localparam logic [ADDR_W-1:0] STRAY     = LOW_ONES & ~HOLD_MASK;

  always_comb begin
    is_pipe  = |addr[ADDR_W-1:GPU_AW];
    bad      = is_pipe && ((addr & STRAY) != '0);
    hold     = addr[HOLD_BIT];
    idx      = addr[ADDR_W-1:PIPE_LSB];
    void_hit = void_map[idx];
  end
endmodule

// File: rtl/ridx_slot.sv
module ridx_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));
endmodule

// File: rtl/ridx_engine.sv
module ridx_engine
  import ridx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_sel,
  input  logic [ADDR_W-1:0]  cmd_data,
  input  logic [PIPE_N-1:0]  void_map,
  output logic               gpu_valid,
  input  logic               gpu_ready,
  output logic [GPU_AW-1:0]  gpu_addr,
  output logic [ADDR_W-1:0]  gpu_data,
  output logic               pipe_valid,
  input  logic               pipe_ready,
  output logic [PIPE_IW-1:0] pipe_idx,
  output logic [ADDR_W-1:0]  pipe_data,
  output logic               addr_err,
  output logic [ADDR_W-1:0]  addr_a,
  output logic [ADDR_W-1:0]  addr_b,
  output logic               act_b
);
  localparam logic [ADDR_W-1:0] PIPE_STEP = ADDR_W'(1) << PIPE_LSB;
  localparam int GW = GPU_AW + ADDR_W;
  localparam int PW = PIPE_IW + ADDR_W;

  sel_e               sel;
  logic               acc, is_addr, is_data;
  logic [ADDR_W-1:0]  cur, probe, next_addr;
  logic               c_pipe, c_bad, c_hold, c_void;
  logic [PIPE_IW-1:0] c_idx;
  logic               g_load, p_load, g_free, p_free;
  logic [GW-1:0]      g_bus;
  logic [PW-1:0]      p_bus;

  assign sel     = sel_e'(cmd_sel);
  assign acc     = cmd_valid && cmd_ready;
  assign is_addr = (sel == SEL_ADDR_A) || (sel == SEL_ADDR_B);
  assign is_data = (sel == SEL_DATA);
  assign cur     = act_b ? addr_b : addr_a;
  assign probe   = is_data ? cur : cmd_data;

  ridx_classify u_cls (
    .addr(probe), .void_map(void_map), .is_pipe(c_pipe), .bad(c_bad),
    .hold(c_hold), .void_hit(c_void), .idx(c_idx)
  );

  always_comb begin
    if (!c_pipe)     next_addr = cur + ADDR_W'(1);
    else if (c_hold) next_addr = cur;
    else             next_addr = cur + PIPE_STEP;
  end

  assign g_load = acc && is_data && !c_pipe;
  assign p_load = acc && c_pipe && !c_bad && (is_data || (is_addr && c_void));

  ridx_slot #(.W(GW)) u_gslot (
    .clk(clk), .rst_n(rst_n), .load(g_load),
    .load_data({cur[GPU_AW-1:0], cmd_data}), .ready(gpu_ready),
    .valid(gpu_valid), .data(g_bus), .free(g_free)
  );

  ridx_slot #(.W(PW)) u_pslot (
    .clk(clk), .rst_n(rst_n), .load(p_load),
    .load_data({c_idx, is_data ? cmd_data : '0}), .ready(pipe_ready),
    .valid(pipe_valid), .data(p_bus), .free(p_free)
  );

  assign {gpu_addr, gpu_data}  = g_bus;
  assign {pipe_idx, pipe_data} = p_bus;
  assign cmd_ready = g_free && p_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_a   <= '0;
      addr_b   <= '0;
      act_b    <= 1'b0;
      addr_err <= 1'b0;
    end else begin
      addr_err <= acc && (is_addr || is_data) && c_bad;
      if (acc) begin
        case (sel)
          SEL_ADDR_A: begin addr_a <= cmd_data; act_b <= 1'b0; end
          SEL_ADDR_B: begin addr_b <= cmd_data; act_b <= 1'b1; end
          SEL_DATA: if (!c_bad) begin
            if (act_b) addr_b <= next_addr;
            else       addr_a <= next_addr;
          end
          default: ;
        endcase
      end
    end
  end

  p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gpu_valid && pipe_valid));
  p_err_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !gpu_valid && !pipe_valid);
  p_gpu_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_data && !c_pipe |=> gpu_valid && (cur == $past(cur) + ADDR_W'(1)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_data && c_pipe && !c_bad && c_hold |=> pipe_valid && (cur == $past(cur)));
  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (sel == SEL_RSVD) |=> $stable(addr_a) && $stable(addr_b) && $stable(act_b)
                                 && !gpu_valid && !pipe_valid);
  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gpu_valid && !gpu_ready) || (pipe_valid && !pipe_ready) |-> !cmd_ready);
endmodule

// File: tb/ridx_engine_tb_top.sv
`timescale 1ns/1ps
module ridx_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_sel = 2'd0;
  logic [31:0] cmd_data = '0;
  logic [255:0] void_map;
  logic        gpu_valid, gpu_ready = 1'b1;
  logic [15:0] gpu_addr;
  logic [31:0] gpu_data;
  logic        pipe_valid, pipe_ready = 1'b1;
  logic [7:0]  pipe_idx;
  logic [31:0] pipe_data;
  logic        addr_err;
  logic [31:0] addr_a, addr_b;
  logic        act_b;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ridx_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sel(cmd_sel), .cmd_data(cmd_data), .void_map(void_map),
    .gpu_valid(gpu_valid), .gpu_ready(gpu_ready), .gpu_addr(gpu_addr), .gpu_data(gpu_data),
    .pipe_valid(pipe_valid), .pipe_ready(pipe_ready), .pipe_idx(pipe_idx), .pipe_data(pipe_data),
    .addr_err(addr_err), .addr_a(addr_a), .addr_b(addr_b), .act_b(act_b)
  );

  // expected state computed from the requirements
  logic [31:0] ma = '0, mb = '0;
  logic        mact = 1'b0;
  logic        e_gv, e_pv, e_err;
  logic [15:0] e_ga;
  logic [7:0]  e_pi;
  logic [31:0] e_gd, e_pd;
  string       tag;

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [31:0] a);
    return (a > 32'hFFFF) && ((a & 32'h00FB_FFFF) != 0);
  endfunction

  task automatic model(input logic [1:0] s, input logic [31:0] d);
    logic [31:0] c;
    e_gv = 0; e_pv = 0; e_err = 0; e_ga = '0; e_gd = '0; e_pi = '0; e_pd = '0;
    if (s < 2) begin
      if (s == 0) ma = d; else mb = d;
      mact = s[0];
      tag = "R2";
      if (d > 32'hFFFF) begin
        if (is_bad(d)) begin e_err = 1; tag = "R6"; end
        else if (void_map[d[31:24]]) begin e_pv = 1; e_pi = d[31:24]; e_pd = 0; tag = "R7"; end
      end
    end else if (s == 2) begin
      c = mact ? mb : ma;
      if (c > 32'hFFFF) begin
        if (is_bad(c)) begin e_err = 1; tag = "R6"; end
        else begin
          e_pv = 1; e_pi = c[31:24]; e_pd = d;
          if (c[18]) tag = "R5";
          else begin c = c + 32'h0100_0000; tag = "R4"; end
        end
      end else begin
        e_gv = 1; e_ga = c[15:0]; e_gd = d; c = c + 1; tag = "R3";
      end
      if (mact) mb = c; else ma = c;
    end else tag = "R9";
  endtask

  task automatic compare();
    chk(gpu_valid == e_gv, {tag, " gpu_valid"}, 64'(gpu_valid), 64'(e_gv));
    if (e_gv) chk({gpu_addr, gpu_data} == {e_ga, e_gd}, {tag, " gpu fields"},
                  64'({gpu_addr, gpu_data}), 64'({e_ga, e_gd}));
    chk(pipe_valid == e_pv, {tag, " pipe_valid"}, 64'(pipe_valid), 64'(e_pv));
    if (e_pv) chk({pipe_idx, pipe_data} == {e_pi, e_pd}, {tag, " pipe fields"},
                  64'({pipe_idx, pipe_data}), 64'({e_pi, e_pd}));
    chk(addr_err == e_err, {tag, " addr_err"}, 64'(addr_err), 64'(e_err));
    chk({addr_a, addr_b} == {ma, mb} && act_b == mact, {tag, " address regs"},
        {addr_a, addr_b}, {ma, mb});
    chk(!(gpu_valid && pipe_valid), "R10 both valid", 64'({gpu_valid, pipe_valid}), 64'(0));
  endtask

  task automatic send(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_sel = s; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    model(s, d);
    compare();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) void_map[i] = (i % 7 == 3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({addr_a, addr_b} == 64'd0 && !act_b, "R1 address regs", {addr_a, addr_b}, 64'd0);
    chk(!gpu_valid && !pipe_valid && !addr_err, "R1 outputs idle",
        64'({gpu_valid, pipe_valid, addr_err}), 64'd0);

    // GPU stream across the 0xFFFF boundary into malformed space (R3, R6)
    send(2'd0, 32'h0000_FFF0);
    for (int k = 0; k < 20; k++) send(2'd2, 32'hA000_0000 + 32'(k));
    // stream via B starting at 0 (R2, R3)
    send(2'd1, 32'h0000_0000);
    for (int k = 0; k < 4; k++) send(2'd2, 32'h5555_0000 ^ 32'(k));
    // reserved code leaves everything alone (R9)
    send(2'd3, 32'h1234_5678);
    send(2'd2, 32'hCAFE_0001);

    // pipe sweep: every index, hold bit clear and set (R4, R5, R7)
    for (int i = 0; i < 256; i++) begin
      for (int h = 0; h < 2; h++) begin
        send(2'(i & 1), {8'(i), 5'd0, 1'(h), 18'd0});
        send(2'd2, 32'(i * 97 + h));
        send(2'd2, ~32'(i));
      end
    end
    // wrap of the top byte (R4)
    send(2'd0, 32'hFF00_0000);
    send(2'd2, 32'h0000_0011);
    send(2'd2, 32'h0000_0022);

    // malformed addresses, every stray bit (R6)
    for (int b = 0; b < 24; b++) begin
      if (b == 18) continue;
      send(2'd1, 32'h0300_0000 | (32'd1 << b));
      send(2'd2, 32'hDEAD_0000 + 32'(b));
    end

    // back-pressure on GPU port (R8)
    send(2'd0, 32'h0000_0100);
    gpu_ready = 0;
    send(2'd2, 32'h0000_00AA);
    cmd_valid = 1; cmd_sel = 2'd2; cmd_data = 32'h0000_00BB;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!cmd_ready, "R8 cmd_ready during stall", 64'(cmd_ready), 64'd0);
      chk(gpu_valid && gpu_addr == 16'h0100 && gpu_data == 32'hAA, "R8 held write",
          64'({gpu_valid, gpu_addr, gpu_data}), 64'({1'b1, 16'h0100, 32'hAA}));
    end
    cmd_valid = 0;
    gpu_ready = 1;
    @(negedge clk);
    chk(!gpu_valid, "R8 drained", 64'(gpu_valid), 64'd0);
    chk(addr_a == 32'h101, "R8 address after stall", 64'(addr_a), 64'h101);
    ma = 32'h101;
    send(2'd2, 32'h0000_00BB);

    // back-pressure on pipe port (R8)
    send(2'd0, 32'h2204_0000);
    pipe_ready = 0;
    send(2'd2, 32'h0000_0077);
    cmd_valid = 1; cmd_sel = 2'd3; cmd_data = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!cmd_ready && pipe_valid && pipe_idx == 8'h22 && pipe_data == 32'h77,
          "R8 pipe stall", 64'({cmd_ready, pipe_valid, pipe_idx, pipe_data}),
          64'({1'b0, 1'b1, 8'h22, 32'h77}));
    end
    cmd_valid = 0;
    pipe_ready = 1;
    @(negedge clk);
    chk(!pipe_valid, "R8 pipe drained", 64'(pipe_valid), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule